// File: doc/BRIEF.md
# Trace Capture and Stop-Trigger Controller

This block steers processor trace words into a circular on-chip trace memory and decides when that capture ends. Software sets it up through a small word-addressed register bus. It programs a window of memory bounded by start and end word addresses, a reference PC and a PC-match mode, a post-trigger delay count, and the set of trigger sources that may stop capture. Capture begins when the enable bit in the control register is written from 0 to 1. While capture is running, each valid trace word is written to memory at the current address. The address steps through the window and wraps from the end back to the start, and every wrap is counted.

A stop trigger can come from a software stop bit, a PC match on a retired instruction, the processor trigger input or the cross-trigger input. The block records which source fired in sticky status flags. After the trigger a countdown runs. It counts either memory words written or retired instructions. When the count reaches zero, capture is complete. The memory stays write-protected until the enable bit is cleared and set again. Two trigger outputs can be raised when the trigger fires, when the capture completes, or both.

Top module: `trc_stop_ctrl`

## Requirements
- R1: Register word offsets are: identity 0x00 (a constant, 0x7ACE0010 by default), control 0x04, status 0x08, last captured word 0x0C, address 0x10, reference PC 0x14, PC-match control 0x18, delay count 0x1C, window start 0x20, window end 0x24. Unmapped offsets read 0. Control keeps bits 0, 2, 4, 5, 9, 16, 17, 20 and 21, and all other control bits read 0. After reset, control, address and status read 0, except that status bits 12:8 hold the memory size.
- R2: Capture starts only on a 0-to-1 write of control bit 0. The start loads the window start into the address and clears the wrap count. While capture is inactive, trace input writes nothing to memory. Status bit 0 is set while capture is active.
- R3: Writing 1 to control bit 1 during capture fires a stop trigger and sets status bit 1, without setting any source flag. Control bit 1 always reads 0.
- R4: Control bits 2, 4 and 5 enable the PC-match, processor-trigger and cross-trigger sources. A firing source sets status bit 1 together with its own flag (bit 2, 4 or 5). A disabled source has no effect.
- R5: Status bits 1, 2, 4 and 5 stay set until control bit 0 is written from 1 to 0, which clears them.
- R6: After a trigger, status bit 0 stays set until the delay count reaches zero. If the count is already zero when the trigger fires, capture ends on the next cycle.
- R7: With control bit 9 at 0, the delay count drops by one for each word written to memory. With bit 9 at 1, it drops by one for each retired instruction and ignores memory writes.
- R8: Once capture has completed, no trace word reaches memory until control bit 0 has been cleared and set again.
- R9: The address register holds the word address in bits 20:0 and the wrap count in bits 30:21. A write at the window end sends the next write to the window start and adds one to the wrap count.
- R10: When the wrap count rolls over from all ones to zero, address bit 31 is set. It stays set until control bit 0 is written from 1 to 0.
- R11: PC-match control bits 4:0 give the number of low PC bits ignored when comparing a retired PC with the reference PC. With bit 31 at 0, a match means the PC is inside that range. With bit 31 at 1, a match means it is outside.
- R12: The processor trigger output is raised when a trigger fires if control bit 16 is set, and when capture completes if bit 17 is set. Control bits 20 and 21 do the same for the cross-trigger output. Both outputs stay high until control bit 0 is written from 1 to 0. Status bits 16 and 17 mirror the processor and cross-trigger outputs.
- R13: Status bits 12:8 report log2 of the trace memory size in bytes, which is 12 for the default 10-bit word address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_en_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | Register write when 1, read when 0 |
| bus_addr_i | input | 6 | Register byte offset |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Register read data for bus_addr_i (combinational) |
| trc_valid_i | input | 1 | Trace word valid |
| trc_data_i | input | 32 | Trace word |
| insn_retire_i | input | 1 | One instruction retires this cycle |
| pc_i | input | 32 | PC of the retiring instruction |
| proc_trig_i | input | 1 | Processor trigger input |
| xtrig_i | input | 1 | Cross-trigger input |
| mem_we_o | output | 1 | Trace memory write enable |
| mem_addr_o | output | ADDR_W | Trace memory word address |
| mem_wdata_o | output | 32 | Trace memory write data |
| proc_trig_o | output | 1 | Processor trigger output |
| xtrig_o | output | 1 | Cross-trigger output |

## Verification
The assertions take every input as sampled on the rising clock edge. A register write takes effect at that edge, and an enable transition and a stop request never share a cycle with a trace word that is expected to land in memory. The wrap check also assumes that the window start is not above the window end, so that the address reaches the end value. The stimulus changes inputs only on the falling edge and keeps the window ordered. It issues one bus access per cycle and drives no trace word in the same cycle as a control write.

// File: rtl/trc_pkg.sv
package trc_pkg;
  localparam logic [5:0] OFS_ID    = 6'h00;
  localparam logic [5:0] OFS_CTRL  = 6'h04;
  localparam logic [5:0] OFS_STAT  = 6'h08;
  localparam logic [5:0] OFS_DATA  = 6'h0C;
  localparam logic [5:0] OFS_ADDR  = 6'h10;
  localparam logic [5:0] OFS_TPC   = 6'h14;
  localparam logic [5:0] OFS_PCM   = 6'h18;
  localparam logic [5:0] OFS_DCNT  = 6'h1C;
  localparam logic [5:0] OFS_WSTRT = 6'h20;
  localparam logic [5:0] OFS_WEND  = 6'h24;

  // control bit positions
  localparam int C_EN     = 0;
  localparam int C_STOP   = 1;
  localparam int C_SRC_PC = 2;
  localparam int C_SRC_PT = 4;
  localparam int C_SRC_CT = 5;
  localparam int C_UNIT   = 9;
  localparam int C_PT_TRG = 16;
  localparam int C_PT_DON = 17;
  localparam int C_CT_TRG = 20;
  localparam int C_CT_DON = 21;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CAPT  = 2'd1,
    ST_DELAY = 2'd2,
    ST_DONE  = 2'd3
  } trc_state_e;
endpackage

// File: rtl/trc_pc_match.sv
module trc_pc_match (
  input  logic [31:0] pc_i,
  input  logic [31:0] ref_i,
  input  logic [4:0]  ign_i,
  input  logic        inv_i,
  output logic        hit_o
);
  logic [31:0] keep;
  logic        in_rng;

  assign keep   = 32'hFFFF_FFFF << ign_i;
  assign in_rng = ((pc_i ^ ref_i) & keep) == 32'h0;
  assign hit_o  = in_rng ^ inv_i;
endmodule

// File: rtl/trc_addr_gen.sv
module trc_addr_gen #(
  parameter int ADDR_W = 10,
  parameter int WRAP_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              restart_i,
  input  logic              clr_sat_i,
  input  logic              adv_i,
  input  logic [ADDR_W-1:0] start_i,
  input  logic [ADDR_W-1:0] end_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [WRAP_W-1:0] wrap_o,
  output logic              sat_o
);
  localparam logic [WRAP_W-1:0] WRAP_MAX = '1;

  logic at_end;
  assign at_end = addr_o == end_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o <= '0;
      wrap_o <= '0;
      sat_o  <= 1'b0;
    end else if (restart_i) begin
      addr_o <= start_i;
      wrap_o <= '0;
      sat_o  <= 1'b0;
    end else begin
      if (clr_sat_i) sat_o <= 1'b0;
      if (adv_i) begin
        if (at_end) begin
          addr_o <= start_i;
          wrap_o <= wrap_o + 1'b1;
          if (wrap_o == WRAP_MAX && !clr_sat_i) sat_o <= 1'b1;
        end else begin
          addr_o <= addr_o + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/trc_delay_cnt.sv
module trc_delay_cnt #(
  parameter int DCNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DCNT_W-1:0] load_val_i,
  input  logic              dec_i,
  output logic [DCNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_o <= '0;
    else if (load_i)                 cnt_o <= load_val_i;
    else if (dec_i && cnt_o != '0)   cnt_o <= cnt_o - 1'b1;
  end
endmodule

// File: rtl/trc_stop_ctrl.sv
module trc_stop_ctrl
  import trc_pkg::*;
#(
  parameter int          ADDR_W   = 10,
  parameter int          WRAP_W   = 10,
  parameter int          DCNT_W   = 16,
  parameter logic [31:0] ID_VALUE = 32'h7ACE_0010
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_en_i,
  input  logic              bus_we_i,
  input  logic [5:0]        bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  input  logic              trc_valid_i,
  input  logic [31:0]       trc_data_i,
  input  logic              insn_retire_i,
  input  logic [31:0]       pc_i,
  input  logic              proc_trig_i,
  input  logic              xtrig_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  output logic              proc_trig_o,
  output logic              xtrig_o
);
  localparam int          MEMSZ  = ADDR_W + 2;
  localparam int          APAD_W = 21 - ADDR_W;
  localparam logic [4:0]  MEMSZ5 = 5'(MEMSZ);

  // control fields
  logic ctl_en, src_pc, src_pt, src_ct, unit_insn;
  logic pt_on_trg, pt_on_don, ct_on_trg, ct_on_don;
  logic [ADDR_W-1:0] wstrt_q, wend_q;
  logic [31:0]       tpc_q, last_q;
  logic [4:0]        pcm_ign_q;
  logic              pcm_inv_q;

  trc_state_e state_q, state_d;
  logic trig_q, cause_pc_q, cause_pt_q, cause_ct_q;
  logic pto_q, cto_q;

  logic wr_any, wr_ctrl, en_rise, en_fall, sw_stop;
  logic pcm_hit, hit_pc, hit_pt, hit_ct, trig_fire;
  logic st_capt, st_delay, active, unit_evt, done_evt;
  logic dcnt_ld;
  logic [DCNT_W-1:0] dcnt;
  logic [ADDR_W-1:0] waddr;
  logic [WRAP_W-1:0] wrap;
  logic              sat;

  assign wr_any  = bus_en_i & bus_we_i;
  assign wr_ctrl = wr_any & (bus_addr_i == OFS_CTRL);
  assign en_rise = wr_ctrl &  bus_wdata_i[C_EN] & ~ctl_en;
  assign en_fall = wr_ctrl & ~bus_wdata_i[C_EN] &  ctl_en;
  assign sw_stop = wr_ctrl &  bus_wdata_i[C_STOP];
  assign dcnt_ld = wr_any & (bus_addr_i == OFS_DCNT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      {ctl_en, src_pc, src_pt, src_ct, unit_insn} <= '0;
      {pt_on_trg, pt_on_don, ct_on_trg, ct_on_don} <= '0;
      wstrt_q   <= '0;
      wend_q    <= '0;
      tpc_q     <= '0;
      pcm_ign_q <= '0;
      pcm_inv_q <= 1'b0;
    end else if (wr_any) begin
      unique case (bus_addr_i)
        OFS_CTRL: begin
          ctl_en    <= bus_wdata_i[C_EN];
          src_pc    <= bus_wdata_i[C_SRC_PC];
          src_pt    <= bus_wdata_i[C_SRC_PT];
          src_ct    <= bus_wdata_i[C_SRC_CT];
          unit_insn <= bus_wdata_i[C_UNIT];
          pt_on_trg <= bus_wdata_i[C_PT_TRG];
          pt_on_don <= bus_wdata_i[C_PT_DON];
          ct_on_trg <= bus_wdata_i[C_CT_TRG];
          ct_on_don <= bus_wdata_i[C_CT_DON];
        end
        OFS_TPC:   tpc_q <= bus_wdata_i;
        OFS_PCM: begin
          pcm_ign_q <= bus_wdata_i[4:0];
          pcm_inv_q <= bus_wdata_i[31];
        end
        OFS_WSTRT: wstrt_q <= bus_wdata_i[ADDR_W-1:0];
        OFS_WEND:  wend_q  <= bus_wdata_i[ADDR_W-1:0];
        default: ;
      endcase
    end
  end

  trc_pc_match u_pcm (
    .pc_i  (pc_i),
    .ref_i (tpc_q),
    .ign_i (pcm_ign_q),
    .inv_i (pcm_inv_q),
    .hit_o (pcm_hit)
  );

  assign st_capt   = state_q == ST_CAPT;
  assign st_delay  = state_q == ST_DELAY;
  assign active    = st_capt | st_delay;
  assign hit_pc    = src_pc & insn_retire_i & pcm_hit;
  assign hit_pt    = src_pt & proc_trig_i;
  assign hit_ct    = src_ct & xtrig_i;
  assign trig_fire = st_capt & ~en_fall & (sw_stop | hit_pc | hit_pt | hit_ct);

  assign mem_we_o    = trc_valid_i & active;
  assign mem_addr_o  = waddr;
  assign mem_wdata_o = trc_data_i;
  assign unit_evt    = unit_insn ? insn_retire_i : mem_we_o;

  trc_delay_cnt #(.DCNT_W(DCNT_W)) u_dly (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (dcnt_ld),
    .load_val_i (bus_wdata_i[DCNT_W-1:0]),
    .dec_i      (st_delay & unit_evt),
    .cnt_o      (dcnt)
  );

  trc_addr_gen #(.ADDR_W(ADDR_W), .WRAP_W(WRAP_W)) u_agen (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (en_rise),
    .clr_sat_i (en_fall),
    .adv_i     (mem_we_o),
    .start_i   (wstrt_q),
    .end_i     (wend_q),
    .addr_o    (waddr),
    .wrap_o    (wrap),
    .sat_o     (sat)
  );

  always_comb begin
    state_d  = state_q;
    done_evt = 1'b0;
    if (en_fall) begin
      state_d = ST_IDLE;
    end else if (en_rise) begin
      state_d = ST_CAPT;
    end else begin
      unique case (state_q)
        ST_CAPT: if (trig_fire) begin
          if (dcnt == '0) begin
            state_d  = ST_DONE;
            done_evt = 1'b1;
          end else begin
            state_d = ST_DELAY;
          end
        end
        ST_DELAY: if (dcnt == '0 || (unit_evt && dcnt == DCNT_W'(1))) begin
          state_d  = ST_DONE;
          done_evt = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      {trig_q, cause_pc_q, cause_pt_q, cause_ct_q} <= '0;
      pto_q   <= 1'b0;
      cto_q   <= 1'b0;
      last_q  <= '0;
    end else begin
      state_q <= state_d;
      if (mem_we_o) last_q <= trc_data_i;
      if (en_fall) begin
        {trig_q, cause_pc_q, cause_pt_q, cause_ct_q} <= '0;
        pto_q <= 1'b0;
        cto_q <= 1'b0;
      end else begin
        if (trig_fire) begin
          trig_q <= 1'b1;
          if (hit_pc) cause_pc_q <= 1'b1;
          if (hit_pt) cause_pt_q <= 1'b1;
          if (hit_ct) cause_ct_q <= 1'b1;
        end
        if ((trig_fire & pt_on_trg) | (done_evt & pt_on_don)) pto_q <= 1'b1;
        if ((trig_fire & ct_on_trg) | (done_evt & ct_on_don)) cto_q <= 1'b1;
      end
    end
  end

  assign proc_trig_o = pto_q;
  assign xtrig_o     = cto_q;

  logic [31:0] ctrl_rd, stat_rd;
  always_comb begin
    ctrl_rd           = '0;
    ctrl_rd[C_EN]     = ctl_en;
    ctrl_rd[C_SRC_PC] = src_pc;
    ctrl_rd[C_SRC_PT] = src_pt;
    ctrl_rd[C_SRC_CT] = src_ct;
    ctrl_rd[C_UNIT]   = unit_insn;
    ctrl_rd[C_PT_TRG] = pt_on_trg;
    ctrl_rd[C_PT_DON] = pt_on_don;
    ctrl_rd[C_CT_TRG] = ct_on_trg;
    ctrl_rd[C_CT_DON] = ct_on_don;
    stat_rd = {14'b0, cto_q, pto_q, 3'b0, MEMSZ5, 2'b0,
               cause_ct_q, cause_pt_q, 1'b0, cause_pc_q, trig_q, active};
  end

  always_comb begin
    unique case (bus_addr_i)
      OFS_ID:    bus_rdata_o = ID_VALUE;
      OFS_CTRL:  bus_rdata_o = ctrl_rd;
      OFS_STAT:  bus_rdata_o = stat_rd;
      OFS_DATA:  bus_rdata_o = last_q;
      OFS_ADDR:  bus_rdata_o = {sat, wrap, {APAD_W{1'b0}}, waddr};
      OFS_TPC:   bus_rdata_o = tpc_q;
      OFS_PCM:   bus_rdata_o = {pcm_inv_q, 26'b0, pcm_ign_q};
      OFS_DCNT:  bus_rdata_o = 32'(dcnt);
      OFS_WSTRT: bus_rdata_o = 32'(wstrt_q);
      OFS_WEND:  bus_rdata_o = 32'(wend_q);
      default:   bus_rdata_o = '0;
    endcase
  end

  logic unused_wdata;
  assign unused_wdata = ^{bus_wdata_i, bus_en_i};
endmodule

// File: rtl/trc_stop_chk.sv
module trc_stop_chk #(
  parameter int ADDR_W = 10,
  parameter int WRAP_W = 10,
  parameter int DCNT_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_fall,
  input logic              en_rise,
  input logic              trig_q,
  input logic              cause_pc_q,
  input logic              cause_pt_q,
  input logic              cause_ct_q,
  input logic              sat,
  input logic [WRAP_W-1:0] wrap,
  input logic [ADDR_W-1:0] waddr,
  input logic [ADDR_W-1:0] wend_q,
  input logic              mem_we_o,
  input logic              st_delay,
  input logic              dcnt_ld,
  input logic [DCNT_W-1:0] dcnt,
  input logic              proc_trig_o
);
  // R5
  sticky_trig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_q && !en_fall) |=> trig_q);

  // R4
  cause_implies_trig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cause_pc_q || cause_pt_q || cause_ct_q) |-> trig_q);

  // R10
  sat_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sat && !en_fall && !en_rise) |=> sat);

  // R9
  wrap_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && waddr == wend_q && !en_rise) |=> (wrap == WRAP_W'($past(wrap) + 1'b1)));

  // R6
  delay_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_delay && !dcnt_ld) |=> (dcnt <= $past(dcnt)));

  // R12
  ptrig_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(proc_trig_o) |-> $past(en_fall));
endmodule

bind trc_stop_ctrl trc_stop_chk #(.ADDR_W(ADDR_W), .WRAP_W(WRAP_W), .DCNT_W(DCNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_fall     (en_fall),
  .en_rise     (en_rise),
  .trig_q      (trig_q),
  .cause_pc_q  (cause_pc_q),
  .cause_pt_q  (cause_pt_q),
  .cause_ct_q  (cause_ct_q),
  .sat         (sat),
  .wrap        (wrap),
  .waddr       (waddr),
  .wend_q      (wend_q),
  .mem_we_o    (mem_we_o),
  .st_delay    (st_delay),
  .dcnt_ld     (dcnt_ld),
  .dcnt        (dcnt),
  .proc_trig_o (proc_trig_o)
);

// File: tb/sim_trc_stop_ctrl.sv
module sim_trc_stop_ctrl;
  localparam int CLK_P  = 10;
  localparam int ADDR_W = 10;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic bus_en = 1'b0, bus_we = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic trc_valid = 1'b0, retire = 1'b0, ptin = 1'b0, xtin = 1'b0;
  logic [31:0] trc_data = '0, pc = '0, mem_wdata;
  logic mem_we, ptout, xtout;
  logic [ADDR_W-1:0] mem_addr;

  int nvec = 0, nerr = 0;

  always #(CLK_P/2) clk = ~clk;

  trc_stop_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .bus_en_i(bus_en), .bus_we_i(bus_we), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .trc_valid_i(trc_valid), .trc_data_i(trc_data),
    .insn_retire_i(retire), .pc_i(pc),
    .proc_trig_i(ptin), .xtrig_i(xtin),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .proc_trig_o(ptout), .xtrig_o(xtout)
  );

  typedef struct packed {
    logic        wr;
    logic [5:0]  adr;
    logic [31:0] dat;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 6'h00, 32'h7ACE_0010, 4'd1},  // R1 identity
    '{1'b0, 6'h04, 32'h0,         4'd1},  // R1 control reset
    '{1'b0, 6'h08, 32'h0000_0C00, 4'd13}, // R13 size field
    '{1'b0, 6'h10, 32'h0,         4'd9},  // R9 address reset
    '{1'b1, 6'h20, 32'd4,         4'd1},
    '{1'b0, 6'h20, 32'd4,         4'd1},  // R1 window start
    '{1'b1, 6'h24, 32'd7,         4'd1},
    '{1'b0, 6'h24, 32'd7,         4'd1},  // R1 window end
    '{1'b1, 6'h14, 32'h1000,      4'd1},
    '{1'b0, 6'h14, 32'h1000,      4'd1},  // R1 reference PC
    '{1'b1, 6'h18, 32'h8000_00E4, 4'd11},
    '{1'b0, 6'h18, 32'h8000_0004, 4'd11}, // R11 only sense and ignore width kept
    '{1'b1, 6'h18, 32'h0,         4'd11},
    '{1'b0, 6'h18, 32'h0,         4'd11},
    '{1'b1, 6'h1C, 32'd3,         4'd7},
    '{1'b0, 6'h1C, 32'd3,         4'd7},  // R7 delay count
    '{1'b1, 6'h04, 32'hFF33_0236, 4'd1},
    '{1'b0, 6'h04, 32'h0033_0234, 4'd3},  // R1 R3 stop bit reads 0
    '{1'b1, 6'h04, 32'h0,         4'd1},
    '{1'b0, 6'h28, 32'h0,         4'd1}   // R1 unmapped
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    nvec++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input string req, input logic [5:0] a, input logic [31:0] exp);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 check(req, bus_rdata, exp);
    @(negedge clk);
    bus_en = 1'b0;
  endtask

  task automatic push(input string req, input logic exp_we, input logic [ADDR_W-1:0] exp_a);
    trc_valid = 1'b1; trc_data = trc_data + 32'h1111;
    #1 check(req, {31'b0, mem_we}, {31'b0, exp_we});
    if (exp_we) begin
      check(req, 32'(mem_addr), 32'(exp_a));
      check(req, mem_wdata, trc_data);
    end
    @(negedge clk);
    trc_valid = 1'b0;
  endtask

  task automatic ret(input logic [31:0] p);
    retire = 1'b1; pc = p;
    @(negedge clk);
    retire = 1'b0;
  endtask

  initial begin
    #(CLK_P * 200000);
    nerr++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    foreach (VECS[i]) begin
      if (VECS[i].wr) wr(VECS[i].adr, VECS[i].dat);
      else rd($sformatf("R%0d vec%0d", VECS[i].req, i), VECS[i].adr, VECS[i].dat);
    end

    // R2: inactive input ignored, start loads window start
    push("R2 idle", 1'b0, '0);
    wr(6'h04, 32'h1);
    rd("R2 active", 6'h08, 32'h0000_0C01);
    rd("R2 start addr", 6'h10, 32'd4);
    push("R2 first", 1'b1, 10'd4);

    // R9: wrap from end to start
    push("R9", 1'b1, 10'd5);
    push("R9", 1'b1, 10'd6);
    push("R9", 1'b1, 10'd7);
    push("R9 wrap", 1'b1, 10'd4);
    rd("R9 wrap count", 6'h10, 32'h0020_0005);

    // R3 R6 R7: software stop, word-unit countdown of 3
    wr(6'h04, 32'h3);
    rd("R3 trig", 6'h08, 32'h0000_0C03);
    ret(32'h0); ret(32'h0);
    rd("R7 words unit ignores retire", 6'h1C, 32'd3);
    push("R6", 1'b1, 10'd5);
    push("R6", 1'b1, 10'd6);
    rd("R7 count", 6'h1C, 32'd1);
    rd("R6 still active", 6'h08, 32'h0000_0C03);
    push("R6 last", 1'b1, 10'd7);
    rd("R6 ended", 6'h08, 32'h0000_0C02);

    // R8: blocked until toggled
    push("R8 blocked", 1'b0, '0);
    wr(6'h04, 32'h1);
    push("R8 no retoggle", 1'b0, '0);
    rd("R5 sticky", 6'h08, 32'h0000_0C02);
    wr(6'h04, 32'h0);
    rd("R5 cleared", 6'h08, 32'h0000_0C00);

    // R4 R7 R12: processor trigger, retire unit
    wr(6'h1C, 32'd2);
    wr(6'h04, 32'h0021_0211);
    xtin = 1'b1; @(negedge clk); xtin = 1'b0;
    rd("R4 disabled source", 6'h08, 32'h0000_0C01);
    ptin = 1'b1; @(negedge clk); ptin = 1'b0;
    rd("R4 R12 cause", 6'h08, 32'h0001_0C13);
    check("R12 ptout", {31'b0, ptout}, 32'h1);
    check("R12 xtout", {31'b0, xtout}, 32'h0);
    push("R7 words", 1'b1, 10'd4);
    rd("R7 insn unit", 6'h1C, 32'd2);
    ret(32'h0);
    rd("R7 dec", 6'h1C, 32'd1);
    rd("R6 active", 6'h08, 32'h0001_0C13);
    ret(32'h0);
    rd("R12 done", 6'h08, 32'h0003_0C12);
    check("R12 xtout done", {31'b0, xtout}, 32'h1);
    wr(6'h04, 32'h0);
    rd("R12 R5 clear", 6'h08, 32'h0000_0C00);
    check("R12 ptout clear", {31'b0, ptout}, 32'h0);

    // R11 R6: PC match, zero delay
    wr(6'h1C, 32'd0);
    wr(6'h18, 32'h4);
    wr(6'h04, 32'h5);
    ret(32'h2000);
    rd("R11 out of range", 6'h08, 32'h0000_0C01);
    ret(32'h100F);
    rd("R11 R6 in range", 6'h08, 32'h0000_0C06);
    wr(6'h04, 32'h0);
    wr(6'h18, 32'h8000_0004);
    wr(6'h04, 32'h5);
    ret(32'h100A);
    rd("R11 inverted in", 6'h08, 32'h0000_0C01);
    ret(32'h1010);
    rd("R11 inverted out", 6'h08, 32'h0000_0C06);
    wr(6'h04, 32'h0);

    // R10: wrap saturation with one-word window
    wr(6'h20, 32'd9);
    wr(6'h24, 32'd9);
    wr(6'h04, 32'h1);
    trc_valid = 1'b1;
    repeat (1023) @(negedge clk);
    trc_valid = 1'b0;
    rd("R9 max wrap", 6'h10, 32'h7FE0_0009);
    push("R10", 1'b1, 10'd9);
    rd("R10 sat", 6'h10, 32'h8000_0009);
    push("R10", 1'b1, 10'd9);
    rd("R10 sticky", 6'h10, 32'h8020_0009);
    wr(6'h04, 32'h0);
    rd("R10 cleared", 6'h10, 32'h0020_0009);
    wr(6'h04, 32'h1);
    rd("R2 restart", 6'h10, 32'h0000_0009);

    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule